// File: doc/BRIEF.md
# GPIO Output Port Register with Atomic Set and Clear

This block holds the 16-bit output value of a general-purpose I/O port and drives it straight onto the pins. Software reaches it over a simple synchronous register bus that has an address, a write enable, write data and combinational read data. It can change the outputs in three ways:

- It can overwrite the whole output word at once.
- It can write a 32-bit set/clear word, in which the low half forces chosen pins high and the high half forces chosen pins low. This changes individual pins without a read-modify-write sequence.
- It can write a clear-only word that forces chosen pins low.

The set/clear and clear-only locations hold no state of their own. Each write acts once on the output word and leaves nothing behind.

The bus address is decoded into one of four access kinds, and these kinds act as the selector that picks the next-state rule:

| Access kind | Location | Effect on the output word |
|---|---|---|
| `SEL_DATA` | byte offset 0x0C | The word is loaded from the write data. |
| `SEL_SETCLR` | byte offset 0x10 | Set and clear masks are applied. |
| `SEL_CLR` | byte offset 0x14 | Bits are cleared. |
| `SEL_NONE` | any other address | The word holds its value. |

A cycle without a write enable also holds the word, whatever the access kind. A synchronous reset returns the word to zero.

Top module: `gpo_port`

## Requirements
- R1: A synchronous active-high reset sets the output word, and with it `pin_out`, to 0x0000 on the next clock edge.
- R2: A write at offset 0x0C loads bits 15:0 of the write data into the output word on that clock edge, and bits 31:16 are ignored.
- R3: While `bus_addr` is 0x0C, `bus_rdata` returns the output word in bits 15:0 and zeros in bits 31:16. `pin_out` always equals the output word, with no added cycle of delay.
- R4: In a write at offset 0x10, a 1 in data bit i (0..15) makes output bit i equal to 1 after that edge.
- R5: In a write at offset 0x10, a 1 in data bit i+16 makes output bit i equal to 0 after that edge, unless data bit i is also 1.
- R6: In a write at offset 0x10, an output bit whose data bits i and i+16 are both 0 keeps its value. No earlier write affects a later one.
- R7: In a write at offset 0x10 where data bit i and data bit i+16 are both 1, the set wins and output bit i becomes 1.
- R8: In a write at offset 0x14, a 1 in data bit i (0..15) clears output bit i. Zero bits and data bits 31:16 have no effect.
- R9: Reads at offsets 0x10, 0x14 and at every unmapped offset return 0x00000000.
- R10: Writes to unmapped offsets, and cycles with the write enable low, leave the output word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates happen on its rising edge. |
| rst | input | 1 | Synchronous active-high reset. |
| bus_addr | input | 8 | Byte address of the access. |
| bus_we | input | 1 | Write enable; when high, a write is performed this cycle. |
| bus_wdata | input | 32 | Write data. |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational. |
| pin_out | output | 16 | Output pin levels, equal to the output word. |

## Verification
The bench builds the block with its default parameters: 16 pins, an 8-bit address and offsets 0x0C, 0x10 and 0x14. With these values the full 32-bit set/clear word is exercised, including patterns where a bit and its partner 16 places higher are both set. The 8-bit address gives room for unmapped offsets on either side of the three mapped ones, and for an address that matches a mapped offset only in its low bits.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_SETCLR = 2'd2,
        SEL_CLR    = 2'd3
    } acc_sel_e;

endpackage

// File: rtl/gpo_bus_decode.sv
module gpo_bus_decode
    import gpo_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int OFS_DATA   = 'h0C,
    parameter int OFS_SETCLR = 'h10,
    parameter int OFS_CLR    = 'h14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output acc_sel_e          sel,
    output logic              wr_en
);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(OFS_SETCLR);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CLR);

    always_comb begin
        if (addr == A_DATA)        sel = SEL_DATA;
        else if (addr == A_SETCLR) sel = SEL_SETCLR;
        else if (addr == A_CLR)    sel = SEL_CLR;
        else                       sel = SEL_NONE;
    end

    assign wr_en = we && (sel != SEL_NONE);
endmodule

// File: rtl/gpo_bit_next.sv
module gpo_bit_next
    import gpo_pkg::*;
(
    input  acc_sel_e sel,
    input  logic     wr_en,
    input  logic     cur,
    input  logic     lo_bit,
    input  logic     hi_bit,
    output logic     nxt
);
    always_comb begin
        nxt = cur;
        if (wr_en) begin
            unique case (sel)
                SEL_DATA:   nxt = lo_bit;
                SEL_SETCLR: nxt = lo_bit ? 1'b1 : (hi_bit ? 1'b0 : cur);
                SEL_CLR:    nxt = lo_bit ? 1'b0 : cur;
                SEL_NONE:   nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/gpo_next_calc.sv
module gpo_next_calc
    import gpo_pkg::*;
#(
    parameter int PIN_W = 16
) (
    input  acc_sel_e           sel,
    input  logic               wr_en,
    input  logic [PIN_W-1:0]   cur,
    input  logic [2*PIN_W-1:0] wdata,
    output logic [PIN_W-1:0]   nxt
);
    for (genvar b = 0; b < PIN_W; b++) begin : g_bit
        gpo_bit_next u_bit (
            .sel    (sel),
            .wr_en  (wr_en),
            .cur    (cur[b]),
            .lo_bit (wdata[b]),
            .hi_bit (wdata[b+PIN_W]),
            .nxt    (nxt[b])
        );
    end
endmodule

// File: rtl/gpo_port.sv
module gpo_port
    import gpo_pkg::*;
#(
    parameter int PIN_W      = 16,
    parameter int ADDR_W     = 8,
    parameter int OFS_DATA   = 'h0C,
    parameter int OFS_SETCLR = 'h10,
    parameter int OFS_CLR    = 'h14,
    localparam int DATA_W    = 2 * PIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PIN_W-1:0]  pin_out
);
    acc_sel_e         sel;
    logic             wr_en;
    logic [PIN_W-1:0] out_q;
    logic [PIN_W-1:0] out_d;

    gpo_bus_decode #(
        .ADDR_W     (ADDR_W),
        .OFS_DATA   (OFS_DATA),
        .OFS_SETCLR (OFS_SETCLR),
        .OFS_CLR    (OFS_CLR)
    ) u_dec (
        .addr  (bus_addr),
        .we    (bus_we),
        .sel   (sel),
        .wr_en (wr_en)
    );

    gpo_next_calc #(.PIN_W(PIN_W)) u_next (
        .sel   (sel),
        .wr_en (wr_en),
        .cur   (out_q),
        .wdata (bus_wdata),
        .nxt   (out_d)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    always_comb begin
        unique case (sel)
            SEL_DATA:   bus_rdata = {{PIN_W{1'b0}}, out_q};
            SEL_SETCLR: bus_rdata = '0;
            SEL_CLR:    bus_rdata = '0;
            SEL_NONE:   bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
endmodule

// File: rtl/gpo_port_chk.sv
module gpo_port_chk #(
    parameter int PIN_W      = 16,
    parameter int ADDR_W     = 8,
    parameter int OFS_DATA   = 'h0C,
    parameter int OFS_SETCLR = 'h10,
    parameter int OFS_CLR    = 'h14
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [2*PIN_W-1:0]   bus_wdata,
    input logic [2*PIN_W-1:0]   bus_rdata,
    input logic [PIN_W-1:0]     pin_out
);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(OFS_SETCLR);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CLR);

    logic [PIN_W-1:0] lo_w;
    logic [PIN_W-1:0] hi_w;
    logic             mapped;
    assign lo_w   = bus_wdata[PIN_W-1:0];
    assign hi_w   = bus_wdata[2*PIN_W-1:PIN_W];
    assign mapped = (bus_addr == A_DATA) || (bus_addr == A_SETCLR) || (bus_addr == A_CLR);

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (pin_out == '0));

    p_data_load_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_DATA) |=> (pin_out == $past(lo_w)));

    p_readback_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_DATA) |-> (bus_rdata == {{PIN_W{1'b0}}, pin_out}));

    p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SETCLR) |=> ((pin_out & $past(lo_w)) == $past(lo_w)));

    p_clr_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SETCLR) |=> ((pin_out & $past(hi_w) & ~$past(lo_w)) == '0));

    p_keep_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SETCLR)
        |=> (((pin_out ^ $past(pin_out)) & ~($past(lo_w) | $past(hi_w))) == '0));

    p_bitclr_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR) |=> (pin_out == ($past(pin_out) & ~$past(lo_w))));

    p_zero_read_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != A_DATA) |-> (bus_rdata == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && mapped) |=> $stable(pin_out));
endmodule

bind gpo_port gpo_port_chk #(
    .PIN_W      (PIN_W),
    .ADDR_W     (ADDR_W),
    .OFS_DATA   (OFS_DATA),
    .OFS_SETCLR (OFS_SETCLR),
    .OFS_CLR    (OFS_CLR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out)
);

// File: tb/gpo_port_tb_top.sv
module gpo_port_tb_top;
    localparam int PIN_W = 16;
    localparam int ADDR_W = 8;
    localparam int WDOG = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [PIN_W-1:0]  pin_out;

    always #5 clk = ~clk;

    gpo_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out)
    );

    typedef struct {
        int          due;
        logic [15:0] pins;
        bit          rchk;
        logic [31:0] rexp;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          cycle = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [15:0] model = '0;
    bit          done = 1'b0;

    always @(posedge clk) cycle <= cycle + 1;

    // monitor: compare results in the cycle they are due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cycle) begin
            exp_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (pin_out !== it.pins) begin
                n_errors++;
                $display("FAIL %s pin_out: actual %h expected %h", it.req, pin_out, it.pins);
            end
            if (it.rchk) begin
                n_checks++;
                if (bus_rdata !== it.rexp) begin
                    n_errors++;
                    $display("FAIL %s bus_rdata: actual %h expected %h", it.req, bus_rdata, it.rexp);
                end
            end
        end
    end

    task automatic push(input int due, input bit rchk, input logic [31:0] rexp, input string req);
        exp_t it;
        it.due = due; it.pins = model; it.rchk = rchk; it.rexp = rexp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        case (a)
            8'h0C: model = d[15:0];
            8'h10: model = (model & ~d[31:16]) | d[15:0];
            8'h14: model = model & ~d[15:0];
            default: ;
        endcase
        push(cycle + 1, 1'b0, '0, req);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b0; bus_wdata = 32'hFFFF_FFFF;
        push(cycle, 1'b1, exp, req);
    endtask

    task automatic do_reset(input string req);
        @(posedge clk); #1;
        rst = 1'b1; bus_we = 1'b0;
        model = '0;
        push(cycle + 1, 1'b0, '0, req);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        rd(8'h0C, 32'h0, "R1 reset state");
        // R2: direct write, upper half ignored
        wr(8'h0C, 32'hABCD_1234, "R2 data load");
        rd(8'h0C, 32'h0000_1234, "R3 readback");
        wr(8'h0C, 32'h0000_FFFF, "R2 data load all ones");
        rd(8'h0C, 32'h0000_FFFF, "R3 readback all ones");
        // R5 clear via upper half
        wr(8'h10, 32'h00F0_0000, "R5 clear via high half");
        rd(8'h0C, 32'h0000_FF0F, "R3 readback after clear");
        // R4 set
        wr(8'h0C, 32'h0000_0000, "R2 data load zero");
        wr(8'h10, 32'h0000_8001, "R4 set bits 15 and 0");
        // R6 zero write: no change, no memory of earlier write
        wr(8'h10, 32'h0000_0000, "R6 zero write keeps");
        wr(8'h10, 32'h0001_0000, "R6 later write independent");
        rd(8'h0C, 32'h0000_8000, "R6 readback");
        // R7 both set and clear on same bit
        wr(8'h10, 32'h00FF_000F, "R7 set wins");
        wr(8'h10, 32'hFFFF_FFFF, "R7 set wins all bits");
        // R8 bit clear, upper half ignored
        wr(8'h14, 32'hFFFF_00F0, "R8 bit clear");
        rd(8'h0C, 32'h0000_FF0F, "R8 readback");
        wr(8'h14, 32'h0000_0000, "R8 zero clear keeps");
        // R9 zero reads
        rd(8'h10, 32'h0, "R9 read setclr is zero");
        rd(8'h14, 32'h0, "R9 read bitclr is zero");
        rd(8'h00, 32'h0, "R9 read unmapped zero");
        rd(8'h8C, 32'h0, "R9 read alias zero");
        // R10 unmapped writes and idle cycles
        wr(8'h18, 32'h0000_FFFF, "R10 unmapped write ignored");
        wr(8'h8C, 32'h0000_0000, "R10 alias write ignored");
        wr(8'h0D, 32'h0000_0000, "R10 misaligned write ignored");
        rd(8'h0C, 32'h0000_FF0F, "R10 readback after ignored writes");
        do_reset("R1 mid-run reset");
        rd(8'h0C, 32'h0, "R1 readback after reset");
        @(posedge clk); #1 bus_we = 1'b0;
        repeat (3) @(posedge clk);
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule